// File: doc/BRIEF.md
# Disk Controller Interrupt Queue

This block holds the set of interrupts a multi-drive disk controller still owes its host. One source is the controller itself (a function has completed); the others are one seek-completion source per drive. The queue drives a single level-sensitive interrupt request line, and the host answers each request with an acknowledge strobe.

On every acknowledge the lowest pending source is served and removed from the queue. The block then reports which drive was served and answers with a fixed vector. If the queue turns out to be empty, it answers with zero instead (a passive release). The request line stays high after an acknowledge for as long as sources remain queued. Control/status writes, completion and seek events, and resets add to, prune or empty the queue according to the interrupt-enable (IE) and done flags that the surrounding controller supplies.

Top module: `dsk_irq_queue`

## Requirements
- R1: Queue position 0 belongs to the controller-completion source, and position d+1 belongs to the seek source of drive d. A served position d+1 loads `ack_drv` with d. A served position 0 loads `ack_drv` with the stored last-used drive.
- R2: A control/status write (`cs_wr`) whose new IE value `wr_ie` is 0 empties the queue and drops `irq`.
- R3: A control/status write with `wr_ie`=1, while `done`=1 and the current `ie`=0, queues position 0 and raises `irq`. With `ie` already 1, or with `done`=0, such a write leaves the queue and `irq` unchanged.
- R4: A `seek_done[d]` pulse with `ie`=1 queues position d+1 and raises `irq` only when `done`=1. With `ie`=0 the pulse empties the queue and drops `irq`.
- R5: A `done_set` pulse with `ie`=1 queues position 0 and raises `irq`. With `ie`=0 it empties the queue and drops `irq`.
- R6: A `done_clr` pulse removes position 0 from the queue and drops `irq`. Seek positions already queued stay queued.
- R7: An acknowledge with a non-empty queue clears the lowest-numbered set position. After that, `irq` equals 1 exactly when some position is still set.
- R8: An acknowledge with an empty queue returns `ack_vec`=0, empties the queue, drops `irq` and leaves `ack_drv` unchanged.
- R9: `ack_valid` is high in exactly the cycle after an `ack` strobe. `ack_vec` then carries the parameter `VECTOR` for a served source and 0 otherwise. When `ack_valid` is low, `ack_vec` is 0.
- R10: `rst` or `ctl_reset` empties the queue, drops `irq` and zeroes the stored last-used drive. Only `rst` also clears `ack_drv` and the response.
- R11: Effects that land in the same cycle apply in a fixed order: acknowledge, control/status write, `done_clr`, `done_set`, seek pulses (drive 0 upward), then `ctl_reset`. A later set wins over an earlier clear of the same position.
- R12: `drv_load` stores `drv_num` as the last-used drive. A served controller position reports the value stored before that cycle's load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| ctl_reset | input | 1 | Controller reset pulse |
| ie | input | 1 | Current interrupt-enable flag |
| done | input | 1 | Current done flag |
| cs_wr | input | 1 | Control/status write event |
| wr_ie | input | 1 | IE value carried by the write |
| done_set | input | 1 | Function-completion event |
| done_clr | input | 1 | Done-clear event |
| seek_done | input | ND | Per-drive seek-completion pulses |
| drv_load | input | 1 | Load strobe for the last-used drive |
| drv_num | input | ID_W | Last-used drive number |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Level interrupt request |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vec | output | VEC_W | Vector, or 0 for passive release |
| ack_drv | output | ID_W | Drive ID of the last served source |

## Verification
Every result of this block is registered once. A change to `irq` caused by an event, a write or an acknowledge shows at the first rising edge after the stimulus. The same edge brings `ack_valid`, `ack_vec` and `ack_drv` for an acknowledge. The bench drives inputs on falling edges and compares all outputs against its own queue model at the next falling edge, one cycle after each stimulus. Queue contents that are not directly visible are brought out by draining the queue with acknowledges and checking each served drive ID in turn.

// File: rtl/dsk_irq_pkg.sv
package dsk_irq_pkg;

    // One cycle's worth of scalar control events
    typedef struct packed {
        logic ack;
        logic cs_wr;
        logic wr_ie;
        logic done_set;
        logic done_clr;
        logic ctl_reset;
    } irq_evt_t;

    // Kind of answer handed back for an acknowledge
    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_VECTOR  = 2'd1,
        RSP_PASSIVE = 2'd2
    } irq_rsp_e;

    function automatic int unsigned drv_id_width(input int unsigned nd);
        return (nd > 1) ? $clog2(nd) : 1;
    endfunction

    function automatic int unsigned pos_width(input int unsigned nd);
        return $clog2(nd + 1);
    endfunction

endpackage

// File: rtl/dsk_irq_pick.sv
module dsk_irq_pick #(
    parameter int QW = 9,
    parameter int IW = 4
) (
    input  logic [QW-1:0] req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest set position wins: scan downward so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = QW - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dsk_irq_update.sv
module dsk_irq_update
    import dsk_irq_pkg::*;
#(
    parameter int ND = 8,
    parameter int IW = 4
) (
    input  logic [ND:0]   q,
    input  logic          irq,
    input  irq_evt_t      ev,
    input  logic          ie,
    input  logic          done,
    input  logic [ND-1:0] seek,
    input  logic          found,
    input  logic [IW-1:0] idx,
    output logic [ND:0]   q_n,
    output logic          irq_n
);
    // Fixed application order: ack, write, done clear, done set, seeks, reset
    always_comb begin
        q_n   = q;
        irq_n = irq;

        if (ev.ack) begin
            if (found) begin
                q_n[idx] = 1'b0;
                irq_n    = |q_n;
            end else begin
                q_n   = '0;
                irq_n = 1'b0;
            end
        end

        if (ev.cs_wr) begin
            if (!ev.wr_ie) begin
                q_n   = '0;
                irq_n = 1'b0;
            end else if (done && !ie) begin
                q_n[0] = 1'b1;
                irq_n  = 1'b1;
            end
        end

        if (ev.done_clr) begin
            q_n[0] = 1'b0;
            irq_n  = 1'b0;
        end

        if (ev.done_set) begin
            if (ie) begin
                q_n[0] = 1'b1;
                irq_n  = 1'b1;
            end else begin
                q_n   = '0;
                irq_n = 1'b0;
            end
        end

        for (int d = 0; d < ND; d++) begin
            if (seek[d]) begin
                if (ie) begin
                    q_n[d+1] = 1'b1;
                    if (done) irq_n = 1'b1;
                end else begin
                    q_n   = '0;
                    irq_n = 1'b0;
                end
            end
        end

        if (ev.ctl_reset) begin
            q_n   = '0;
            irq_n = 1'b0;
        end
    end
endmodule

// File: rtl/dsk_irq_resp.sv
module dsk_irq_resp
    import dsk_irq_pkg::*;
#(
    parameter int          IW     = 4,
    parameter int          ID_W   = 3,
    parameter int          VEC_W  = 9,
    parameter logic [VEC_W-1:0] VECTOR = 9'h0B8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic             found,
    input  logic [IW-1:0]    idx,
    input  logic [ID_W-1:0]  last_drv,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vec,
    output logic [ID_W-1:0]  ack_drv
);
    irq_rsp_e rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q   <= RSP_IDLE;
            ack_drv <= '0;
        end else if (ack) begin
            if (found) begin
                rsp_q   <= RSP_VECTOR;
                ack_drv <= (idx == '0) ? last_drv : ID_W'(idx - IW'(1));
            end else begin
                rsp_q   <= RSP_PASSIVE;
            end
        end else begin
            rsp_q <= RSP_IDLE;
        end
    end

    always_comb begin
        ack_valid = (rsp_q != RSP_IDLE);
        ack_vec   = (rsp_q == RSP_VECTOR) ? VECTOR : '0;
    end
endmodule

// File: rtl/dsk_irq_queue.sv
module dsk_irq_queue
    import dsk_irq_pkg::*;
#(
    parameter int               ND     = 8,
    parameter int               VEC_W  = 9,
    parameter logic [VEC_W-1:0] VECTOR = 9'h0B8,
    localparam int              ID_W   = drv_id_width(ND)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_reset,
    input  logic             ie,
    input  logic             done,
    input  logic             cs_wr,
    input  logic             wr_ie,
    input  logic             done_set,
    input  logic             done_clr,
    input  logic [ND-1:0]    seek_done,
    input  logic             drv_load,
    input  logic [ID_W-1:0]  drv_num,
    input  logic             ack,
    output logic             irq,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vec,
    output logic [ID_W-1:0]  ack_drv
);
    localparam int QW = ND + 1;
    localparam int IW = pos_width(ND);

    logic [QW-1:0]   queue_q, queue_n;
    logic            irq_n;
    logic [ID_W-1:0] last_drv_q;
    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    irq_evt_t        evt;

    always_comb begin
        evt.ack       = ack;
        evt.cs_wr     = cs_wr;
        evt.wr_ie     = wr_ie;
        evt.done_set  = done_set;
        evt.done_clr  = done_clr;
        evt.ctl_reset = ctl_reset;
    end

    dsk_irq_pick #(.QW(QW), .IW(IW)) u_pick (
        .req   (queue_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    dsk_irq_update #(.ND(ND), .IW(IW)) u_update (
        .q     (queue_q),
        .irq   (irq),
        .ev    (evt),
        .ie    (ie),
        .done  (done),
        .seek  (seek_done),
        .found (pick_found),
        .idx   (pick_idx),
        .q_n   (queue_n),
        .irq_n (irq_n)
    );

    dsk_irq_resp #(
        .IW(IW), .ID_W(ID_W), .VEC_W(VEC_W), .VECTOR(VECTOR)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .ack       (ack),
        .found     (pick_found),
        .idx       (pick_idx),
        .last_drv  (last_drv_q),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec),
        .ack_drv   (ack_drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            queue_q <= '0;
            irq     <= 1'b0;
        end else begin
            queue_q <= queue_n;
            irq     <= irq_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_reset)
            last_drv_q <= '0;
        else if (drv_load)
            last_drv_q <= drv_num;
    end
endmodule

module dsk_irq_queue_chk #(
    parameter int               ND     = 8,
    parameter int               VEC_W  = 9,
    parameter logic [VEC_W-1:0] VECTOR = 9'h0B8,
    parameter int               ID_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_reset,
    input logic             ie,
    input logic             done,
    input logic             cs_wr,
    input logic             wr_ie,
    input logic             done_set,
    input logic             done_clr,
    input logic [ND-1:0]    seek_done,
    input logic             drv_load,
    input logic [ID_W-1:0]  drv_num,
    input logic             ack,
    input logic             irq,
    input logic             ack_valid,
    input logic [VEC_W-1:0] ack_vec,
    input logic [ID_W-1:0]  ack_drv
);
    // R10
    rst_quiet_chk: assert property (@(posedge clk) rst |=> (!irq && !ack_valid && ack_drv == '0));

    // R10
    ctl_reset_drop_chk: assert property (@(posedge clk) disable iff (rst) ctl_reset |=> !irq);

    // R9
    resp_follows_ack_chk: assert property (@(posedge clk) disable iff (rst) ack |=> ack_valid);

    // R9
    resp_only_after_ack_chk: assert property (@(posedge clk) disable iff (rst) !ack |=> (!ack_valid && ack_vec == '0));

    // R9
    resp_value_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_vec == VECTOR || ack_vec == '0));

    // R2
    ie_clear_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_wr && !wr_ie && !done_set && seek_done == '0) |=> !irq);

    // R6
    done_clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (done_clr && !done_set && seek_done == '0) |=> !irq);

    // R5
    done_set_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (done_set && ie && !ctl_reset) |=> irq);

    // R8
    passive_keeps_drv_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_vec == '0) |-> $stable(ack_drv));
endmodule

bind dsk_irq_queue dsk_irq_queue_chk #(
    .ND(ND), .VEC_W(VEC_W), .VECTOR(VECTOR), .ID_W(ID_W)
) u_chk (.*);

// File: tb/dsk_irq_queue_tb.sv
module dsk_irq_queue_tb;
    localparam int ND  = 8;
    localparam int IDW = 3;
    localparam int VW  = 9;
    localparam logic [VW-1:0] VEC = 9'h0B8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, ctl_reset, ie, done, cs_wr, wr_ie, done_set, done_clr, drv_load, ack;
    logic [ND-1:0]  seek_done;
    logic [IDW-1:0] drv_num;
    logic           irq, ack_valid;
    logic [VW-1:0]  ack_vec;
    logic [IDW-1:0] ack_drv;

    dsk_irq_queue #(.ND(ND), .VEC_W(VW), .VECTOR(VEC)) u_dut (
        .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .ie(ie), .done(done),
        .cs_wr(cs_wr), .wr_ie(wr_ie), .done_set(done_set), .done_clr(done_clr),
        .seek_done(seek_done), .drv_load(drv_load), .drv_num(drv_num), .ack(ack),
        .irq(irq), .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_drv(ack_drv)
    );

    // Reference state, kept from the requirements
    logic [ND:0]    m_q;
    logic           m_irq, m_av;
    logic [VW-1:0]  m_vec;
    logic [IDW-1:0] m_drv, m_ld;
    int n_chk = 0;
    int n_err = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic clear_pulses();
        ctl_reset = 0; cs_wr = 0; wr_ie = 0; done_set = 0; done_clr = 0;
        seek_done = '0; drv_load = 0; ack = 0; rst = 0;
    endtask

    // Next reference state for the stimulus now on the pins
    task automatic model_step();
        logic [ND:0] q;
        logic r;
        int k;
        q = m_q; r = m_irq;
        m_av = ack; m_vec = '0;
        if (rst) begin
            m_q = '0; m_irq = 0; m_av = 0; m_drv = '0; m_ld = '0;
            return;
        end
        if (ack) begin                      // R7 / R8
            k = -1;
            for (int i = 0; i <= ND; i++) if (m_q[i] && k < 0) k = i;
            if (k >= 0) begin
                q[k] = 1'b0; r = (q != '0); m_vec = VEC;
                m_drv = (k == 0) ? m_ld : IDW'(k - 1);   // R1
            end else begin
                q = '0; r = 0;
            end
        end
        if (cs_wr) begin                    // R2 / R3
            if (!wr_ie) begin q = '0; r = 0; end
            else if (done && !ie) begin q[0] = 1; r = 1; end
        end
        if (done_clr) begin q[0] = 0; r = 0; end          // R6
        if (done_set) begin                 // R5
            if (ie) begin q[0] = 1; r = 1; end
            else begin q = '0; r = 0; end
        end
        for (int d = 0; d < ND; d++) if (seek_done[d]) begin   // R4
            if (ie) begin q[d+1] = 1; if (done) r = 1; end
            else begin q = '0; r = 0; end
        end
        if (ctl_reset) begin q = '0; r = 0; end            // R10
        m_q = q; m_irq = r;
        if (drv_load) m_ld = drv_num;       // R12
        if (ctl_reset) m_ld = '0;
    endtask

    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, "irq", int'(irq), int'(m_irq));
        check(tag, "ack_valid", int'(ack_valid), int'(m_av));
        check(tag, "ack_vec", int'(ack_vec), int'(m_vec));
        check(tag, "ack_drv", int'(ack_drv), int'(m_drv));
        clear_pulses();
    endtask

    task automatic do_ack(input string tag);
        ack = 1; cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        m_q = '0; m_irq = 0; m_av = 0; m_vec = '0; m_drv = '0; m_ld = '0;
        clear_pulses(); ie = 0; done = 0; drv_num = '0;
        seed = $urandom(32'd4242);
        @(negedge clk);
        rst = 1; cyc("R10");
        rst = 1; cyc("R10");

        // R3: enabling with done set queues the controller; R1/R9/R7 on ack
        done = 1; ie = 0;
        drv_num = 3'd5; drv_load = 1; cyc("R12");
        cs_wr = 1; wr_ie = 1; cyc("R3");
        ie = 1;
        cs_wr = 1; wr_ie = 1; cyc("R3");            // IE already set: no change
        do_ack("R1");                               // controller -> drive 5
        do_ack("R8");                               // empty: passive, drive kept

        // R4: seeks without done stay quiet, then R5 raises
        done = 0;
        seek_done = 8'b0100_0100; cyc("R4");
        done_set = 1; done = 1; cyc("R5");
        do_ack("R7");                               // controller first
        do_ack("R7");                               // drive 2
        do_ack("R7");                               // drive 6, irq drops

        // R2: IE-clear write empties
        seek_done = 8'b0000_1000; cyc("R4");
        cs_wr = 1; wr_ie = 0; cyc("R2");
        ie = 0;
        do_ack("R2");

        // R5 with IE clear empties; R4 with IE clear empties
        ie = 1; seek_done = 8'b1000_0000; cyc("R4");
        ie = 0; done_set = 1; cyc("R5");
        do_ack("R5");
        ie = 1; done_set = 1; cyc("R5");
        ie = 0; seek_done = 8'b0000_0001; cyc("R4");
        do_ack("R4");

        // R6: done clear keeps seek positions
        ie = 1; done_set = 1; cyc("R6");
        seek_done = 8'b0000_0010; cyc("R6");
        done_clr = 1; done = 0; cyc("R6");
        do_ack("R6");                               // drive 1, not controller
        do_ack("R6");

        // R11: ack and seek on the same position
        done = 1; seek_done = 8'b0000_0001; cyc("R11");
        ack = 1; seek_done = 8'b0000_0001; cyc("R11");
        do_ack("R11");
        // R12: load and ack together report the old stored drive
        done_set = 1; cyc("R12");
        ack = 1; drv_load = 1; drv_num = 3'd3; cyc("R12");

        // R10: controller reset empties and zeroes the stored drive
        drv_load = 1; drv_num = 3'd7; cyc("R10");
        seek_done = 8'b0001_0000; done_set = 1; cyc("R10");
        ctl_reset = 1; cyc("R10");
        do_ack("R10");
        done_set = 1; cyc("R10");
        do_ack("R10");                              // drive 0 reported

        // Random mix covering R1..R12
        for (int n = 0; n < 4000; n++) begin
            ie   = ($urandom % 4) != 0;
            done = ($urandom % 3) != 0;
            cs_wr     = ($urandom % 12) == 0;
            wr_ie     = ($urandom % 3) != 0;
            done_set  = ($urandom % 10) == 0;
            done_clr  = ($urandom % 14) == 0;
            ctl_reset = ($urandom % 60) == 0;
            drv_load  = ($urandom % 8) == 0;
            drv_num   = IDW'($urandom);
            ack       = ($urandom % 4) == 0;
            for (int d = 0; d < ND; d++) seek_done[d] = ($urandom % 14) == 0;
            rst       = ($urandom % 400) == 0;
            cyc("R11");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule